// File: doc/BRIEF.md
# Latched Fault Status Register Bank

This block collects fault and reset events from a supply and bus-transceiver supervisor and holds them in sticky bits until software reads them. Three registers sit behind a small read port made of an address, a one-cycle read strobe and an 8-bit read-data bus. One register records what caused the last reset. One reports supply conditions. One records failures seen on the bus lines. Detection happens elsewhere: every condition reaches this bank as a digital pulse or level.

A read returns the register as it stood in the strobe cycle. In the same clock edge the register's sticky bits are cleared, so each event is reported once. One supply bit is live. It mirrors a battery-fault level in real time and is never latched or cleared. Power-on reset loads each register with its own value, so the first read of the reset-source register after power-up returns a fixed pattern. An event that arrives in the same cycle as a read of its register is kept for the next read and is never lost.

Top module: `fault_status_bank`

## Requirements
- R1: The reset-source register is at address 0 and uses bits [2:0]. An undervoltage event on the primary supply (`uvEvt`) sets bits 0 and 2. A watchdog event (`wdEvt`) sets bits 1 and 2. An external reset event (`extEvt`) sets only bit 2.
- R2: After power-on reset the reset-source register holds 3'b101, so its first read returns 8'h05. The latched supply bits and all bus failure bits start at zero.
- R3: A read of a register returns its stored value. From the same clock edge its sticky bits are zero, so a repeated read with no new event returns 0 in those bits.
- R4: The supply-status register is at address 1. It has these sticky bits: bit 0, set by a battery overvoltage-kind event (`batOvEvt`); bit 2, set when the second regulator reports on (`reg2OnEvt`); and bit 3, set by third-regulator overtemperature (`reg3HotEvt`).
- R5: Bit 1 of the supply-status register shows the `batFaultLive` input as sampled in the strobe cycle. A read never clears it.
- R6: The bus failure register is at address 2 and uses bits [3:0], all sticky and set by `busEvt`. Bit 0 is a wire interruption. Bit 1 is a short to ground or to the complementary line. Bit 2 is a short to battery. Bit 3 is a short to the logic supply. All zero means no failure.
- R7: An event that arrives in the same cycle as a read of its register does not appear in that read's data. Its bit stays set afterwards and shows up in the next read.
- R8: `rdData` is registered and valid in the cycle after `rdEn`. It is zero in every cycle that follows a cycle without a strobe. Bits above each register's width always read 0.
- R9: A read of an unmapped address (3 and above) returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| uvEvt | input | 1 | Primary-supply undervoltage reset event pulse |
| wdEvt | input | 1 | Watchdog reset event pulse |
| extEvt | input | 1 | External reset event pulse |
| batOvEvt | input | 1 | Battery overvoltage-kind event pulse |
| reg2OnEvt | input | 1 | Second regulator on event |
| reg3HotEvt | input | 1 | Third regulator overtemperature event |
| batFaultLive | input | 1 | Real-time battery fault level |
| busEvt | input | 4 | Bus-line failure event pulses |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdAddr | input | ADDR_W | Register address |
| rdData | output | DATA_W | Registered read data |

## Verification
The bench reads the reset-source register first after reset and expects 8'h05. A bank that cleared everything at power-on would return 0 there, and one that set the wrong default bits would return some other value. It asserts a watchdog event and a bus fault in the very cycle of a read of their register. A design that let the clear win would lose the event, and the bench would see 0 on the follow-up read. It checks that the live battery bit still reads 1 after a read has cleared its neighbours, which catches a clear mask that spans the whole register. It also reads an unmapped address between an event and the proper read, which exposes a decoder that aliases addresses or clears on a miss.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  // Register widths fixed by the bit layouts of the three registers
  localparam int RSRC_W = 3;
  localparam int SUP_W  = 4;
  localparam int BUS_W  = 4;
  localparam int SUP_STICKY_W = SUP_W - 1;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic selRsrc;
    logic selSup;
    logic selBus;
    logic clrRsrc;
    logic clrSup;
    logic clrBus;
  } fsbStrobeT;

endpackage

// File: rtl/fsb_sticky.sv
module fsb_sticky #(
  parameter int              WIDTH = 1,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] setVec,
  input  logic             clr,
  output logic [WIDTH-1:0] q
);

  // Each bit keeps its own flop; a set in the clear cycle wins
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q[i] <= INIT[i];
      end else begin
        q[i] <= (q[i] & ~clr) | setVec[i];
      end
    end
  end

endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] ADDR_RSRC = 0,
  parameter logic [ADDR_W-1:0] ADDR_SUP  = 1,
  parameter logic [ADDR_W-1:0] ADDR_BUS  = 2
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output fsbStrobeT         strb
);

  logic hitRsrc;
  logic hitSup;
  logic hitBus;

  assign hitRsrc = rdEn && (rdAddr == ADDR_RSRC);
  assign hitSup  = rdEn && (rdAddr == ADDR_SUP);
  assign hitBus  = rdEn && (rdAddr == ADDR_BUS);

  always_comb begin
    strb         = '0;
    strb.selRsrc = hitRsrc;
    strb.selSup  = hitSup;
    strb.selBus  = hitBus;
    strb.clrRsrc = hitRsrc;
    strb.clrSup  = hitSup;
    strb.clrBus  = hitBus;
  end

endmodule

// File: rtl/fsb_datapath.sv
module fsb_datapath
  import fsb_pkg::*;
#(
  parameter int                       DATA_W    = 8,
  parameter logic [RSRC_W-1:0]        RSRC_INIT = 3'b101,
  parameter logic [SUP_STICKY_W-1:0]  SUP_INIT  = '0,
  parameter logic [BUS_W-1:0]         BUS_INIT  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsbStrobeT         strb,
  input  logic              uvEvt,
  input  logic              wdEvt,
  input  logic              extEvt,
  input  logic              batOvEvt,
  input  logic              reg2OnEvt,
  input  logic              reg3HotEvt,
  input  logic              batFaultLive,
  input  logic [BUS_W-1:0]  busEvt,
  output logic [DATA_W-1:0] rdData,
  output logic [RSRC_W-1:0] rsrcState
);

  logic [RSRC_W-1:0]       rsrcSet;
  logic [RSRC_W-1:0]       rsrcQ;
  logic [SUP_STICKY_W-1:0] supSet;
  logic [SUP_STICKY_W-1:0] supQ;
  logic [SUP_W-1:0]        supView;
  logic [BUS_W-1:0]        busQ;
  logic [DATA_W-1:0]       readMux;

  // Reset-source encoding: any reset kind flags bit 2, causes add their own bit
  assign rsrcSet = {uvEvt | wdEvt | extEvt, wdEvt, uvEvt};
  assign supSet  = {reg3HotEvt, reg2OnEvt, batOvEvt};

  fsb_sticky #(.WIDTH(RSRC_W), .INIT(RSRC_INIT)) rsrcReg_i (
    .clk(clk), .rstN(rstN), .setVec(rsrcSet), .clr(strb.clrRsrc), .q(rsrcQ)
  );

  fsb_sticky #(.WIDTH(SUP_STICKY_W), .INIT(SUP_INIT)) supReg_i (
    .clk(clk), .rstN(rstN), .setVec(supSet), .clr(strb.clrSup), .q(supQ)
  );

  fsb_sticky #(.WIDTH(BUS_W), .INIT(BUS_INIT)) busReg_i (
    .clk(clk), .rstN(rstN), .setVec(busEvt), .clr(strb.clrBus), .q(busQ)
  );

  // Live battery bit sits between latched bit 0 and bits 2..3
  assign supView = {supQ[2], supQ[1], batFaultLive, supQ[0]};

  always_comb begin
    readMux = '0;
    if (strb.selRsrc) begin
      readMux[RSRC_W-1:0] = rsrcQ;
    end else if (strb.selSup) begin
      readMux[SUP_W-1:0] = supView;
    end else if (strb.selBus) begin
      readMux[BUS_W-1:0] = busQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= readMux;
    end
  end

  assign rsrcState = rsrcQ;

endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
  import fsb_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_RSRC = 0,
  parameter logic [ADDR_W-1:0] ADDR_SUP  = 1,
  parameter logic [ADDR_W-1:0] ADDR_BUS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              uvEvt,
  input  logic              wdEvt,
  input  logic              extEvt,
  input  logic              batOvEvt,
  input  logic              reg2OnEvt,
  input  logic              reg3HotEvt,
  input  logic              batFaultLive,
  input  logic [3:0]        busEvt,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  fsbStrobeT         strb;
  logic [RSRC_W-1:0] rsrcState;

  fsb_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_RSRC(ADDR_RSRC), .ADDR_SUP(ADDR_SUP), .ADDR_BUS(ADDR_BUS)
  ) ctrl_i (
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  fsb_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .uvEvt(uvEvt), .wdEvt(wdEvt), .extEvt(extEvt),
    .batOvEvt(batOvEvt), .reg2OnEvt(reg2OnEvt), .reg3HotEvt(reg3HotEvt),
    .batFaultLive(batFaultLive), .busEvt(busEvt),
    .rdData(rdData), .rsrcState(rsrcState)
  );

endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_RSRC = 0,
  parameter logic [ADDR_W-1:0] ADDR_SUP  = 1,
  parameter logic [ADDR_W-1:0] ADDR_BUS  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              batFaultLive,
  input logic              uvEvt,
  input logic              wdEvt,
  input logic [2:0]        rsrcState
);

  logic unmapped;
  assign unmapped = (rdAddr != ADDR_RSRC) && (rdAddr != ADDR_SUP) && (rdAddr != ADDR_BUS);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0)); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:4] == '0); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped) |=> (rdData == '0)); // R9

  AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped && !uvEvt && !wdEvt) |=> (rsrcState == $past(rsrcState))); // R9

  AST_LIVE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_SUP) |=> (rdData[1] == $past(batFaultLive))); // R5

  AST_RSRC_IMPLY: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_RSRC) |=> ((rdData[0] | rdData[1]) ? rdData[2] : 1'b1)); // R1

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_RSRC && wdEvt) |=> (rsrcState[1] && rsrcState[2])); // R7

endmodule

bind fault_status_bank fsb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ADDR_RSRC(ADDR_RSRC), .ADDR_SUP(ADDR_SUP), .ADDR_BUS(ADDR_BUS)
) chk_i (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .batFaultLive(batFaultLive), .uvEvt(uvEvt), .wdEvt(wdEvt), .rsrcState(rsrcState)
);

// File: tb/fault_status_bank_tb.sv
`timescale 1ns/1ps
module fault_status_bank_tb_top;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_RSRC = 0;
  localparam logic [ADDR_W-1:0] A_SUP  = 1;
  localparam logic [ADDR_W-1:0] A_BUS  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvEvt = 0, wdEvt = 0, extEvt = 0;
  logic batOvEvt = 0, reg2OnEvt = 0, reg3HotEvt = 0, batFaultLive = 0;
  logic [3:0] busEvt = '0;
  logic rdEn = 0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];

  always #10 clk = ~clk;

  fault_status_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .uvEvt(uvEvt), .wdEvt(wdEvt), .extEvt(extEvt),
    .batOvEvt(batOvEvt), .reg2OnEvt(reg2OnEvt), .reg3HotEvt(reg3HotEvt),
    .batFaultLive(batFaultLive), .busEvt(busEvt),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Event pulse for one cycle, no read
  task automatic pulse(input logic [2:0] rEv, input logic [2:0] sEv, input logic [3:0] bEv);
    @(negedge clk);
    {extEvt, wdEvt, uvEvt} = rEv;
    {reg3HotEvt, reg2OnEvt, batOvEvt} = sEv;
    busEvt = bEv;
    @(negedge clk);
    {extEvt, wdEvt, uvEvt} = '0;
    {reg3HotEvt, reg2OnEvt, batOvEvt} = '0;
    busEvt = '0;
  endtask

  // Read with optional events in the strobe cycle; expected value queued
  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                        input string tag, input logic [2:0] rEv, input logic [3:0] bEv);
    @(negedge clk);
    rdAddr = a;
    rdEn = 1'b1;
    {extEvt, wdEvt, uvEvt} = rEv;
    busEvt = bEv;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
    {extEvt, wdEvt, uvEvt} = '0;
    busEvt = '0;
  endtask

  // Monitor: a strobe seen at an edge yields data checked at the next falling edge
  initial begin
    forever begin
      logic sawRead;
      @(posedge clk);
      sawRead = rdEn;
      @(negedge clk);
      if (sawRead && expQ.size() > 0) begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 idle data zero", rdData, 8'h00);

    // Power-on pattern
    doRead(A_RSRC, 8'h05, "R2 reset-source power-on", 3'b000, 4'h0);
    doRead(A_SUP,  8'h00, "R2 supply power-on", 3'b000, 4'h0);
    doRead(A_BUS,  8'h00, "R2 bus power-on", 3'b000, 4'h0);
    doRead(A_RSRC, 8'h00, "R3 reset-source cleared", 3'b000, 4'h0);

    // Reset-source encoding ({ext,wd,uv})
    pulse(3'b010, 3'b000, 4'h0);
    doRead(A_RSRC, 8'h06, "R1 watchdog", 3'b000, 4'h0);
    doRead(A_RSRC, 8'h00, "R3 watchdog cleared", 3'b000, 4'h0);
    pulse(3'b100, 3'b000, 4'h0);
    doRead(A_RSRC, 8'h04, "R1 external only", 3'b000, 4'h0);
    pulse(3'b001, 3'b000, 4'h0);
    doRead(A_RSRC, 8'h05, "R1 undervoltage", 3'b000, 4'h0);

    // Supply register with live bit
    batFaultLive = 1'b1;
    pulse(3'b000, 3'b111, 4'h0);
    doRead(A_SUP, 8'h0F, "R4 supply latched bits", 3'b000, 4'h0);
    doRead(A_SUP, 8'h02, "R5 live bit survives read", 3'b000, 4'h0);
    batFaultLive = 1'b0;
    doRead(A_SUP, 8'h00, "R5 live bit follows input", 3'b000, 4'h0);
    pulse(3'b000, 3'b010, 4'h0);
    doRead(A_SUP, 8'h04, "R4 regulator-2 on only", 3'b000, 4'h0);

    // Bus failure register
    pulse(3'b000, 3'b000, 4'b0101);
    doRead(A_BUS, 8'h05, "R6 wire open and short to battery", 3'b000, 4'h0);
    pulse(3'b000, 3'b000, 4'b1010);
    doRead(A_BUS, 8'h0A, "R6 short to ground and logic supply", 3'b000, 4'h0);
    doRead(A_BUS, 8'h00, "R3 bus cleared", 3'b000, 4'h0);

    // Collisions of event and read
    doRead(A_RSRC, 8'h00, "R7 collision read old value", 3'b010, 4'h0);
    doRead(A_RSRC, 8'h06, "R7 collision event kept", 3'b000, 4'h0);
    doRead(A_BUS,  8'h00, "R7 bus collision read old value", 3'b000, 4'b0001);
    doRead(A_BUS,  8'h01, "R7 bus collision event kept", 3'b000, 4'h0);

    // Unmapped address
    pulse(3'b001, 3'b000, 4'b1000);
    doRead(4'd7, 8'h00, "R9 unmapped reads zero", 3'b000, 4'h0);
    doRead(4'd3, 8'h00, "R9 unmapped reads zero", 3'b000, 4'h0);
    doRead(A_RSRC, 8'h05, "R9 unmapped left reset-source", 3'b000, 4'h0);
    doRead(A_BUS,  8'h08, "R9 unmapped left bus", 3'b000, 4'h0);

    repeat (3) @(negedge clk);
    check("R8 idle data zero at end", rdData, 8'h00);
    if (expQ.size() != 0) begin
      check("R8 all reads answered", 8'(expQ.size()), 8'h00);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule